// File: doc/BRIEF.md
# Edge-Point PWM Generator Channel

This block produces one pulse-width-modulated output from a fast system clock. A two-stage prescaler, a power-of-two stage followed by a linear stage, slows the clock down to a count rate. A free-running 8-bit period counter steps at that rate and wraps after a programmable terminal value. Two compare points inside the period set the waveform: the output goes high when the counter reaches the rising point and goes low when it reaches the falling point.

All settings arrive as plain input ports. There are separate enables for the count clock and for the pin, a polarity flip, an open-drain drive mode and an idle level. A sync control decides whether new compare points wait for the next period boundary or take effect at once. The outputs are the pin value and an active-low output enable that a pad cell can use directly.

Top module: `edge_pwm_chan`

## Requirements
- R1: With exponent e (4 bits), linear divider L (8 bits) and terminal value P (8 bits), the counter runs 0,1,...,P and wraps, and the output repeats every 2^e × (L+1) × (P+1) clock cycles.
- R2: With rising point Ra and falling point Fa different, the output is high for ((Fa − Ra) mod (P+1)) counter steps in every period. The level changes one clock after the counter reaches the matching point.
- R3: When the rising and falling points are equal (including both zero), the output stays high for the whole period.
- R4: While the clock enable is low, the counter and prescaler are held at zero, the output does not toggle, and the pin shows the idle level XOR the invert control.
- R5: While the pin enable is low, the output enable is high (released) and the pin shows the idle level XOR the invert control.
- R6: The invert control flips the pin polarity in every state, so a waveform high for h of N cycles becomes high for N − h.
- R7: In open-drain mode the output enable is low only while the pin value is low. In push-pull mode it is low whenever the pin is enabled.
- R8: With the sync control low, new compare points are taken up only at the counter wrap, so the period that is running finishes with the old points.
- R9: With the sync control high, new compare points act from the next clock on, within the running period.
- R10: A low-to-high change of the clock enable restarts the prescaler and counter from zero. With the rising point at zero, the output goes high one clock after the enable and stays high for 2^e × (L+1) × Fa clocks.
- R11: After reset, with all controls zero, the pin is low and the output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_exp | input | EXP_W | Power-of-two prescaler exponent |
| cfg_div_lin | input | LIN_W | Linear prescaler divider minus one |
| cfg_period | input | CNT_W | Counter terminal value (period − 1) |
| cfg_rise | input | CNT_W | Counter value that sets the output |
| cfg_fall | input | CNT_W | Counter value that clears the output |
| cfg_clk_en | input | 1 | Runs the prescaler and counter |
| cfg_pin_en | input | 1 | Lets the channel drive its pin |
| cfg_invert | input | 1 | Flips output polarity |
| cfg_open_drain | input | 1 | Drive only the low level |
| cfg_idle_lvl | input | 1 | Level shown while the channel is disabled |
| cfg_sync_off | input | 1 | 1: compare points act at once; 0: at the wrap |
| pwm_pin | output | 1 | Pin value |
| pwm_oe_n | output | 1 | Active-low output enable |

## Verification
The bench counts high cycles and rising edges over whole periods. A prescaler that divides by one too many, or a counter that wraps at P instead of P+1, therefore shows up as a wrong count. It changes the falling point just after a rising edge. In deferred mode the high run of that period must keep its old length, and in immediate mode it must shorten in the same period: swapped or missing shadow logic gives the wrong run length in one mode or the other. Equal compare points must give a solid high level, and a design that treats them as a zero-width pulse shows a constant low instead. Re-enabling the clock after a pause must give a high run of exactly the predicted length. A prescaler that is not cleared on the restart stretches or shortens that first run.

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;

    localparam int DEF_EXP_W = 4;
    localparam int DEF_LIN_W = 8;
    localparam int DEF_CNT_W = 8;

    // pin-side controls, independent of counter width
    typedef struct packed {
        logic enable;
        logic invert;
        logic open_drain;
        logic idle_lvl;
    } pin_ctl_t;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_PUSH = 2'd1,
        DRV_OD   = 2'd2
    } drive_e;

    function automatic drive_e pick_drive(input pin_ctl_t c);
        if (!c.enable)
            return DRV_OFF;
        else if (c.open_drain)
            return DRV_OD;
        else
            return DRV_PUSH;
    endfunction

    // active-low enable for a given drive mode and pin value
    function automatic logic oe_n_of(input drive_e m, input logic val);
        case (m)
            DRV_PUSH: return 1'b0;
            DRV_OD:   return val;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/epwm_prescaler.sv
module epwm_prescaler #(
    parameter int EXP_W = edge_pwm_pkg::DEF_EXP_W,
    parameter int LIN_W = edge_pwm_pkg::DEF_LIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic [LIN_W-1:0] cfg_lin,
    output logic             tick
);
    localparam int POW_W = (1 << EXP_W) - 1;

    logic [POW_W-1:0] pow_cnt;
    logic [POW_W-1:0] pow_mask;
    logic [LIN_W-1:0] lin_cnt;
    logic             pow_hit;
    logic             lin_hit;

    always_comb begin
        for (int i = 0; i < POW_W; i++)
            pow_mask[i] = (i < int'(cfg_exp));
    end

    assign pow_hit = ((pow_cnt & pow_mask) == pow_mask);
    assign lin_hit = (lin_cnt >= cfg_lin);
    assign tick    = en && pow_hit && lin_hit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pow_cnt <= '0;
            lin_cnt <= '0;
        end else begin
            pow_cnt <= pow_hit ? '0 : pow_cnt + POW_W'(1);
            if (pow_hit)
                lin_cnt <= lin_hit ? '0 : lin_cnt + LIN_W'(1);
        end
    end

    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pow_cnt == '0) && (lin_cnt == '0)); // R10

endmodule

// File: rtl/epwm_period_ctr.sv
module epwm_period_ctr #(
    parameter int CNT_W = edge_pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // a terminal value lowered below the count still wraps at once
    assign wrap = tick && (cnt >= cfg_period);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick && (cnt < cfg_period) |=> cnt == $past(cnt) + CNT_W'(1)); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0); // R10

endmodule

// File: rtl/epwm_wave.sv
module epwm_wave #(
    parameter int CNT_W = edge_pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sync_off,
    input  logic [CNT_W-1:0] cfg_rise,
    input  logic [CNT_W-1:0] cfg_fall,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    output logic             lvl
);
    logic [CNT_W-1:0] act_rise;
    logic [CNT_W-1:0] act_fall;
    logic [CNT_W-1:0] eff_rise;
    logic [CNT_W-1:0] eff_fall;

    // shadow copies follow the inputs while stopped and at each wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            act_rise <= '0;
            act_fall <= '0;
        end else if (!en || wrap) begin
            act_rise <= cfg_rise;
            act_fall <= cfg_fall;
        end
    end

    assign eff_rise = sync_off ? cfg_rise : act_rise;
    assign eff_fall = sync_off ? cfg_fall : act_fall;

    always_ff @(posedge clk) begin
        if (rst || !en)
            lvl <= 1'b0;
        else if (eff_rise == eff_fall)
            lvl <= 1'b1;
        else if (cnt == eff_rise)
            lvl <= 1'b1;
        else if (cnt == eff_fall)
            lvl <= 1'b0;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        en && !wrap |=> $stable({act_rise, act_fall})); // R8

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        en && (eff_rise == eff_fall) |=> lvl); // R3

endmodule

// File: rtl/epwm_pin_stage.sv
module epwm_pin_stage
    import edge_pwm_pkg::*;
(
    input  pin_ctl_t ctl,
    input  logic     run,
    input  logic     lvl,
    output logic     pin,
    output logic     oe_n
);
    drive_e mode;
    logic   src;

    always_comb begin
        src  = (run && ctl.enable) ? lvl : ctl.idle_lvl;
        pin  = src ^ ctl.invert;
        mode = pick_drive(ctl);
        oe_n = oe_n_of(mode, pin);
    end

endmodule

// File: rtl/edge_pwm_chan.sv
module edge_pwm_chan
    import edge_pwm_pkg::*;
#(
    parameter int EXP_W = DEF_EXP_W,
    parameter int LIN_W = DEF_LIN_W,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] cfg_div_exp,
    input  logic [LIN_W-1:0] cfg_div_lin,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_rise,
    input  logic [CNT_W-1:0] cfg_fall,
    input  logic             cfg_clk_en,
    input  logic             cfg_pin_en,
    input  logic             cfg_invert,
    input  logic             cfg_open_drain,
    input  logic             cfg_idle_lvl,
    input  logic             cfg_sync_off,
    output logic             pwm_pin,
    output logic             pwm_oe_n
);
    logic             tick;
    logic             wrap;
    logic             lvl;
    logic [CNT_W-1:0] cnt;
    pin_ctl_t         ctl;

    assign ctl = '{enable:     cfg_pin_en,
                   invert:     cfg_invert,
                   open_drain: cfg_open_drain,
                   idle_lvl:   cfg_idle_lvl};

    epwm_prescaler #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_clk_en),
        .cfg_exp (cfg_div_exp),
        .cfg_lin (cfg_div_lin),
        .tick    (tick)
    );

    epwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_clk_en),
        .tick       (tick),
        .cfg_period (cfg_period),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    epwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_clk_en),
        .sync_off (cfg_sync_off),
        .cfg_rise (cfg_rise),
        .cfg_fall (cfg_fall),
        .cnt      (cnt),
        .wrap     (wrap),
        .lvl      (lvl)
    );

    epwm_pin_stage u_pin (
        .ctl  (ctl),
        .run  (cfg_clk_en),
        .lvl  (lvl),
        .pin  (pwm_pin),
        .oe_n (pwm_oe_n)
    );

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        cfg_open_drain && !pwm_oe_n |-> !pwm_pin); // R7

    AST_PIN_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !cfg_pin_en |-> pwm_oe_n); // R5

    AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_clk_en |-> pwm_pin == (cfg_idle_lvl ^ cfg_invert)); // R4

endmodule

// File: tb/edge_pwm_chan_bench.sv
`timescale 1ns/1ps
module edge_pwm_chan_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div_exp = '0;
    logic [7:0] div_lin = '0;
    logic [7:0] period = '0;
    logic [7:0] rise = '0;
    logic [7:0] fall = '0;
    logic       clk_en = 1'b0;
    logic       pin_en = 1'b0;
    logic       invert = 1'b0;
    logic       open_drain = 1'b0;
    logic       idle_lvl = 1'b0;
    logic       sync_off = 1'b0;
    logic       pin;
    logic       oe_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_pwm_chan u_edge_pwm_chan (
        .clk            (clk),
        .rst            (rst),
        .cfg_div_exp    (div_exp),
        .cfg_div_lin    (div_lin),
        .cfg_period     (period),
        .cfg_rise       (rise),
        .cfg_fall       (fall),
        .cfg_clk_en     (clk_en),
        .cfg_pin_en     (pin_en),
        .cfg_invert     (invert),
        .cfg_open_drain (open_drain),
        .cfg_idle_lvl   (idle_lvl),
        .cfg_sync_off   (sync_off),
        .pwm_pin        (pin),
        .pwm_oe_n       (oe_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts high samples, rising edges and enable-low samples
    task automatic measure(input int n, output int highs, output int rises,
                           output int oe_low, output int od_bad);
        logic prev;
        highs = 0; rises = 0; oe_low = 0; od_bad = 0;
        prev = pin;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin) highs++;
            if (pin && !prev) rises++;
            if (!oe_n) oe_low++;
            if (!oe_n && pin) od_bad++;
            prev = pin;
        end
    endtask

    task automatic setup(input int e, input int l, input int p, input int r, input int f);
        div_exp = 4'(e); div_lin = 8'(l); period = 8'(p); rise = 8'(r); fall = 8'(f);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pin;
        forever begin
            @(negedge clk);
            if (pin && !prev) break;
            prev = pin;
        end
    endtask

    task automatic t_reset();
        chk("R11", "pin after reset", int'(pin), 0);
        chk("R11", "oe_n after reset", int'(oe_n), 1);
    endtask

    task automatic t_basic();
        int h, r, o, b;
        setup(0, 0, 9, 2, 7);
        clk_en = 1; pin_en = 1; invert = 0; open_drain = 0; sync_off = 0;
        wait_n(30);
        measure(100, h, r, o, b);
        chk("R2", "high cycles P=9 R=2 F=7", h, 50);
        chk("R1", "periods in 100 clocks", r, 10);
        chk("R7", "push-pull oe low cycles", o, 100);
        setup(0, 0, 9, 7, 2);
        wait_n(30);
        measure(100, h, r, o, b);
        chk("R2", "high cycles wrapped R=7 F=2", h, 50);
    endtask

    task automatic t_prescale();
        int h, r, o, b;
        setup(2, 2, 3, 0, 2);
        wait_n(200);
        measure(480, h, r, o, b);
        chk("R1", "high cycles div 12 P=3", h, 240);
        chk("R1", "periods in 480 clocks", r, 10);
    endtask

    task automatic t_full();
        int h, r, o, b;
        setup(0, 0, 9, 0, 0);
        wait_n(30);
        measure(50, h, r, o, b);
        chk("R3", "high cycles R=F=0", h, 50);
        chk("R3", "edges R=F=0", r, 0);
        setup(0, 0, 9, 5, 5);
        wait_n(30);
        measure(50, h, r, o, b);
        chk("R3", "high cycles R=F=5", h, 50);
    endtask

    task automatic t_invert();
        int h, r, o, b;
        setup(0, 0, 9, 1, 4);
        invert = 0;
        wait_n(30);
        measure(100, h, r, o, b);
        chk("R2", "high cycles R=1 F=4", h, 30);
        invert = 1;
        wait_n(5);
        measure(100, h, r, o, b);
        chk("R6", "inverted high cycles", h, 70);
        invert = 0;
    endtask

    task automatic t_open_drain();
        int h, r, o, b;
        setup(0, 0, 9, 1, 4);
        open_drain = 1;
        wait_n(30);
        measure(100, h, r, o, b);
        chk("R7", "od enable-low cycles", o, 70);
        chk("R7", "od enable with pin high", b, 0);
        open_drain = 0;
    endtask

    task automatic t_clk_off();
        int h, r, o, b;
        setup(0, 0, 9, 1, 4);
        clk_en = 0; idle_lvl = 1; invert = 0;
        wait_n(3);
        measure(40, h, r, o, b);
        chk("R4", "stopped high cycles idle=1", h, 40);
        chk("R4", "stopped edges", r, 0);
        chk("R4", "stopped oe low cycles", o, 40);
        invert = 1;
        wait_n(2);
        measure(20, h, r, o, b);
        chk("R6", "stopped inverted idle high cycles", h, 0);
        invert = 0;
    endtask

    task automatic t_pin_off();
        int h, r, o, b;
        setup(0, 0, 9, 1, 4);
        clk_en = 1; pin_en = 0; idle_lvl = 0; invert = 1;
        wait_n(3);
        measure(40, h, r, o, b);
        chk("R5", "pin-off high cycles", h, 40);
        chk("R5", "pin-off oe low cycles", o, 0);
        pin_en = 1; invert = 0;
    endtask

    task automatic t_sync();
        int run;
        setup(0, 0, 9, 0, 5);
        sync_off = 0;
        wait_n(30);
        wait_rise();
        fall = 8'd2;
        run = 1;
        forever begin @(negedge clk); if (!pin) break; run++; end
        chk("R8", "deferred run in old period", run, 5);
        wait_rise();
        run = 1;
        forever begin @(negedge clk); if (!pin) break; run++; end
        chk("R8", "deferred run in next period", run, 2);
    endtask

    task automatic t_immediate();
        int run;
        setup(0, 0, 9, 0, 5);
        sync_off = 1;
        wait_n(30);
        wait_rise();
        fall = 8'd2;
        run = 1;
        forever begin @(negedge clk); if (!pin) break; run++; end
        chk("R9", "immediate run in same period", run, 2);
        sync_off = 0;
    endtask

    task automatic t_restart();
        int h, r, o, b;
        setup(0, 0, 9, 0, 3);
        idle_lvl = 0;
        clk_en = 0;
        wait_n(5);
        clk_en = 1;
        measure(3, h, r, o, b);
        chk("R10", "high in first 3 clocks after enable", h, 3);
        @(negedge clk);
        chk("R10", "low at 4th clock after enable", int'(pin), 0);
        setup(1, 1, 9, 0, 1);
        wait_n(7);
        clk_en = 0;
        wait_n(5);
        clk_en = 1;
        measure(6, h, r, o, b);
        chk("R10", "high after restart with div 4", h, 4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        wait_n(5);
        rst = 0;
        wait_n(2);
        t_reset();
        t_basic();
        t_prescale();
        t_full();
        t_invert();
        t_open_drain();
        t_clk_off();
        t_pin_off();
        t_sync();
        t_immediate();
        t_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule